// File: doc/BRIEF.md
# Coprocessor Load/Store Address Generator

This block takes one 32-bit coprocessor memory-transfer instruction word and the current contents of the base register that the word names. From these it works out the byte address where the transfer starts, and whether the base register must be rewritten and with what value. The addressing mode comes from the indexing bits. The immediate counts words, so it is scaled by four before it is added to or subtracted from the base.

One encoding is not a memory transfer at all. When the pre-index, writeback and up bits are all clear, the word belongs to the two-register transfer extension space. The block then raises a separate flag and suppresses all address work. It also reports an error when such a word names r15 as either core register.

All results come out of one register stage. A strobe marks them valid one cycle after an accepted input. The register fields are passed through raw, so that the extension path can reuse them as its two core register indexes.

Top module: `cop_ls_agen`

## Requirements
- R1: Bit positions: base index `rn_idx` = instr[19:16], `crd_idx` = instr[15:12], `cp_num` = instr[11:8], `xop` = instr[7:4], `crm_idx` = instr[3:0], `is_load` = instr[20]. These outputs are always the raw fields.
- R2: The byte offset is instr[7:0] shifted left by two. The up bit instr[23] set adds the offset to the base, and clear subtracts it.
- R3: With pre bit instr[24]=0, writeback bit instr[21]=0 and up bit 1, the start address is the base and `wb_en` is 0.
- R4: With pre=0 and writeback=1 (post-indexed), the start address is the old base, `wb_en` is 1 and `wb_val` is base±offset.
- R5: With pre=1 and writeback=0 (offset), the start address is base±offset and `wb_en` is 0.
- R6: With pre=1 and writeback=1 (pre-indexed), `wb_en` is 1 and both `wb_val` and the start address equal base±offset.
- R7: When pre, writeback and up are all 0, `ext_space` is 1, `wb_en` is 0, `start_addr` is 0 and `is_long` is 0. Otherwise `ext_space` is 0.
- R8: `err` is 1 only for an extension-space word whose instr[15:12] or instr[19:16] equals 15.
- R9: For a load/store word, `is_long` equals instr[22].
- R10: `out_valid` is high exactly in the cycle after `in_valid`. The outputs keep their values while no new word is accepted, and they reset to zero.
- R11: Address arithmetic wraps modulo 2^32 with no indication.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction word and base value are present |
| instr | input | 32 | Instruction word |
| base_val | input | 32 | Current value of the base register |
| out_valid | output | 1 | Results valid strobe |
| start_addr | output | 32 | First transfer address |
| wb_en | output | 1 | Base register writeback required |
| wb_val | output | 32 | Writeback value |
| rn_idx | output | 4 | Base register index (second core register in extension space) |
| crd_idx | output | 4 | Coprocessor register (first core register in extension space) |
| cp_num | output | 4 | Coprocessor number |
| xop | output | 4 | Extension-space coprocessor opcode field |
| crm_idx | output | 4 | Extension-space CRm field |
| is_load | output | 1 | Load direction (register read in extension space) |
| is_long | output | 1 | Long transfer flag |
| ext_space | output | 1 | Word is a two-register extension transfer |
| err | output | 1 | Unpredictable extension-space register choice |

## Verification
On every cycle, the assertions check the strobe timing, holding the outputs between words, the writeback rules for each indexing mode, the equality of address and writeback value in pre-indexed mode, and that errors and writebacks stay confined to the proper path. Only the bench's scenarios can show that the offset value is right: that the scaling by four, the sign chosen by the up bit and the wrap at both ends of the address space are exact. They also cover the r15 cases placed in each register slot separately.

// File: rtl/cop_ls_pkg.sv
package cop_ls_pkg;

  localparam int INSTR_W = 32;
  localparam int IDX_W   = 4;
  localparam int IMM_W   = 8;

  localparam int BIT_PRE  = 24;
  localparam int BIT_UP   = 23;
  localparam int BIT_LONG = 22;
  localparam int BIT_WB   = 21;
  localparam int BIT_LOAD = 20;

  typedef enum logic [1:0] {
    AM_UNIDX = 2'b00,
    AM_POST  = 2'b01,
    AM_OFFS  = 2'b10,
    AM_PRE   = 2'b11
  } amode_t;

  typedef struct packed {
    logic             pre;
    logic             up;
    logic             lng;
    logic             wb;
    logic             load;
    logic [IDX_W-1:0] rn;
    logic [IDX_W-1:0] crd;
    logic [IDX_W-1:0] cpn;
    logic [IDX_W-1:0] xop;
    logic [IDX_W-1:0] crm;
    logic [IMM_W-1:0] imm;
  } cop_fields_t;

endpackage

// File: rtl/cop_ls_decode.sv
module cop_ls_decode
  import cop_ls_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output cop_fields_t        fields,
  output amode_t             mode,
  output logic               ext_hit
);

  logic [INSTR_W-1:BIT_PRE+1] unused_cond;

  always_comb begin
    fields.pre  = instr[BIT_PRE];
    fields.up   = instr[BIT_UP];
    fields.lng  = instr[BIT_LONG];
    fields.wb   = instr[BIT_WB];
    fields.load = instr[BIT_LOAD];
    fields.rn   = instr[19:16];
    fields.crd  = instr[15:12];
    fields.cpn  = instr[11:8];
    fields.xop  = instr[7:4];
    fields.crm  = instr[3:0];
    fields.imm  = instr[IMM_W-1:0];
    unused_cond = instr[INSTR_W-1:BIT_PRE+1];
  end

  assign mode    = amode_t'({fields.pre, fields.wb});
  assign ext_hit = !fields.pre && !fields.wb && !fields.up;

endmodule

// File: rtl/cop_ls_addr.sv
module cop_ls_addr
  import cop_ls_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_SHIFT = 2
) (
  input  cop_fields_t       fields,
  input  amode_t            mode,
  input  logic              ext_hit,
  input  logic [ADDR_W-1:0] base,
  output logic [ADDR_W-1:0] start,
  output logic              wb_en,
  output logic [ADDR_W-1:0] wb_val,
  output logic              bad_reg
);

  localparam logic [IDX_W-1:0] PC_IDX = {IDX_W{1'b1}};

  function automatic logic [ADDR_W-1:0] scaled_off(input logic [IMM_W-1:0] imm);
    logic [ADDR_W-1:0] wide;
    wide = ADDR_W'(imm);
    return wide << WORD_SHIFT;
  endfunction

  function automatic logic [ADDR_W-1:0] stepped(input logic [ADDR_W-1:0] b,
                                                input logic [IMM_W-1:0]  imm,
                                                input logic              up);
    return up ? (b + scaled_off(imm)) : (b - scaled_off(imm));
  endfunction

  logic [ADDR_W-1:0] moved;

  assign moved   = stepped(base, fields.imm, fields.up);
  assign bad_reg = ext_hit && ((fields.rn == PC_IDX) || (fields.crd == PC_IDX));

  always_comb begin
    start  = '0;
    wb_en  = 1'b0;
    wb_val = base;
    if (!ext_hit) begin
      unique case (mode)
        AM_UNIDX: start = base;
        AM_POST: begin
          start  = base;
          wb_en  = 1'b1;
          wb_val = moved;
        end
        AM_OFFS:  start = moved;
        AM_PRE: begin
          start  = moved;
          wb_en  = 1'b1;
          wb_val = moved;
        end
        default: start = base;
      endcase
    end
  end

endmodule

// File: rtl/cop_ls_outreg.sv
module cop_ls_outreg
  import cop_ls_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [ADDR_W-1:0] d_start,
  input  logic              d_wb_en,
  input  logic [ADDR_W-1:0] d_wb_val,
  input  cop_fields_t       d_fields,
  input  logic              d_ext,
  input  logic              d_err,
  output logic              q_valid,
  output logic [ADDR_W-1:0] q_start,
  output logic              q_wb_en,
  output logic [ADDR_W-1:0] q_wb_val,
  output cop_fields_t       q_fields,
  output logic              q_ext,
  output logic              q_err
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_valid  <= 1'b0;
      q_start  <= '0;
      q_wb_en  <= 1'b0;
      q_wb_val <= '0;
      q_fields <= '0;
      q_ext    <= 1'b0;
      q_err    <= 1'b0;
    end else begin
      q_valid <= load_en;
      if (load_en) begin
        q_start  <= d_start;
        q_wb_en  <= d_wb_en;
        q_wb_val <= d_wb_val;
        q_fields <= d_fields;
        q_ext    <= d_ext;
        q_err    <= d_err;
      end
    end
  end

endmodule

// File: rtl/cop_ls_agen.sv
module cop_ls_agen
  import cop_ls_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_SHIFT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [31:0]       instr,
  input  logic [ADDR_W-1:0] base_val,
  output logic              out_valid,
  output logic [ADDR_W-1:0] start_addr,
  output logic              wb_en,
  output logic [ADDR_W-1:0] wb_val,
  output logic [3:0]        rn_idx,
  output logic [3:0]        crd_idx,
  output logic [3:0]        cp_num,
  output logic [3:0]        xop,
  output logic [3:0]        crm_idx,
  output logic              is_load,
  output logic              is_long,
  output logic              ext_space,
  output logic              err
);

  cop_fields_t       dec_fields;
  amode_t            dec_mode;
  logic              dec_ext;
  logic [ADDR_W-1:0] nxt_start;
  logic              nxt_wb_en;
  logic [ADDR_W-1:0] nxt_wb_val;
  logic              nxt_bad;
  cop_fields_t       reg_fields;
  logic [IMM_W-1:0]  unused_imm;
  logic              unused_up;
  logic              unused_pw;

  cop_ls_decode u_dec (
    .instr   (instr),
    .fields  (dec_fields),
    .mode    (dec_mode),
    .ext_hit (dec_ext)
  );

  cop_ls_addr #(
    .ADDR_W     (ADDR_W),
    .WORD_SHIFT (WORD_SHIFT)
  ) u_addr (
    .fields  (dec_fields),
    .mode    (dec_mode),
    .ext_hit (dec_ext),
    .base    (base_val),
    .start   (nxt_start),
    .wb_en   (nxt_wb_en),
    .wb_val  (nxt_wb_val),
    .bad_reg (nxt_bad)
  );

  cop_ls_outreg #(
    .ADDR_W (ADDR_W)
  ) u_oreg (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (in_valid),
    .d_start  (nxt_start),
    .d_wb_en  (nxt_wb_en),
    .d_wb_val (nxt_wb_val),
    .d_fields (dec_fields),
    .d_ext    (dec_ext),
    .d_err    (nxt_bad),
    .q_valid  (out_valid),
    .q_start  (start_addr),
    .q_wb_en  (wb_en),
    .q_wb_val (wb_val),
    .q_fields (reg_fields),
    .q_ext    (ext_space),
    .q_err    (err)
  );

  assign rn_idx     = reg_fields.rn;
  assign crd_idx    = reg_fields.crd;
  assign cp_num     = reg_fields.cpn;
  assign xop        = reg_fields.xop;
  assign crm_idx    = reg_fields.crm;
  assign is_load    = reg_fields.load;
  assign is_long    = reg_fields.lng && !ext_space;
  assign unused_imm = reg_fields.imm;
  assign unused_up  = reg_fields.up;
  assign unused_pw  = reg_fields.pre ^ reg_fields.wb;

endmodule

// File: rtl/cop_ls_chk.sv
module cop_ls_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [31:0]       instr,
  input logic [ADDR_W-1:0] base_val,
  input logic              out_valid,
  input logic [ADDR_W-1:0] start_addr,
  input logic              wb_en,
  input logic [ADDR_W-1:0] wb_val,
  input logic              ext_space,
  input logic              err,
  input logic              is_long,
  input logic              dec_ext
);

  AST_STROBE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R10
  AST_STROBE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R10
  AST_HOLD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(start_addr) && $stable(wb_val)); // R10
  AST_UNIDX_NOWB: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !instr[24] && !instr[21] && instr[23] |=> !wb_en && start_addr == $past(base_val)); // R3
  AST_POST_OLD_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !instr[24] && instr[21] |=> wb_en && start_addr == $past(base_val)); // R4
  AST_OFFS_NOWB: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && instr[24] && !instr[21] |=> !wb_en); // R5
  AST_PRE_SAME: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && instr[24] && instr[21] |=> wb_en && start_addr == wb_val); // R6
  AST_EXT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && ext_space |-> !wb_en && start_addr == '0 && !is_long); // R7
  AST_EXT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ext_space == $past(dec_ext)); // R7
  AST_ERR_IN_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && err |-> ext_space); // R8
  AST_ERR_PC: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && dec_ext && (instr[15:12] == 4'hF || instr[19:16] == 4'hF) |=> err); // R8

endmodule

bind cop_ls_agen cop_ls_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .instr      (instr),
  .base_val   (base_val),
  .out_valid  (out_valid),
  .start_addr (start_addr),
  .wb_en      (wb_en),
  .wb_val     (wb_val),
  .ext_space  (ext_space),
  .err        (err),
  .is_long    (is_long),
  .dec_ext    (dec_ext)
);

// File: tb/sim_cop_ls_agen.sv
`timescale 1ns/1ps
module sim_cop_ls_agen;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] instr = '0;
  logic [31:0] base_val = '0;
  logic        out_valid;
  logic [31:0] start_addr, wb_val;
  logic        wb_en, is_load, is_long, ext_space, err;
  logic [3:0]  rn_idx, crd_idx, cp_num, xop, crm_idx;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  cop_ls_agen u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr), .base_val(base_val),
    .out_valid(out_valid), .start_addr(start_addr), .wb_en(wb_en), .wb_val(wb_val),
    .rn_idx(rn_idx), .crd_idx(crd_idx), .cp_num(cp_num), .xop(xop), .crm_idx(crm_idx),
    .is_load(is_load), .is_long(is_long), .ext_space(ext_space), .err(err)
  );

  // expected state, held between accepted words
  longint e_start, e_wbv;
  bit     e_wb, e_ext, e_err, e_long, e_load, e_valid;
  int     e_rn, e_crd, e_cp, e_xop, e_crm;
  bit     pend = 1'b0;
  bit     p_ext, p_err, p_long, p_load, p_wb;
  longint p_start, p_wbv;
  int     p_rn, p_crd, p_cp, p_xop, p_crm;

  task automatic chk(input string req, input longint act, input longint exp, input string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // behavioural model of one word: result goes to the pending slot
  task automatic model(input logic [31:0] w, input logic [31:0] b);
    int p, u, n, wb, l;
    longint off, moved, base;
    p = w[24]; u = w[23]; n = w[22]; wb = w[21]; l = w[20];
    base = b;
    off = w[7:0] * 4;
    moved = u ? base + off : base - off;
    if (moved < 0) moved += 64'h1_0000_0000;
    moved = moved % 64'h1_0000_0000;
    p_rn = w[19:16]; p_crd = w[15:12]; p_cp = w[11:8]; p_xop = w[7:4]; p_crm = w[3:0];
    p_load = l;
    p_ext = (p == 0 && wb == 0 && u == 0);
    p_err = p_ext && (p_rn == 15 || p_crd == 15);
    p_long = p_ext ? 0 : n;
    p_wbv = base;
    if (p_ext) begin p_start = 0; p_wb = 0; end
    else if (p == 0 && wb == 0) begin p_start = base; p_wb = 0; end
    else if (p == 0) begin p_start = base; p_wb = 1; p_wbv = moved; end
    else if (wb == 0) begin p_start = moved; p_wb = 0; end
    else begin p_start = moved; p_wb = 1; p_wbv = moved; end
    pend = 1'b1;
  endtask

  task automatic compare_all();
    chk("R10", out_valid, e_valid, "out_valid");
    chk("R3-6/R11", start_addr, e_start, "start_addr");
    chk("R3-6", wb_en, e_wb, "wb_en");
    if (e_wb) chk("R4/R6/R2", wb_val, e_wbv, "wb_val");
    chk("R7", ext_space, e_ext, "ext_space");
    chk("R8", err, e_err, "err");
    chk("R9", is_long, e_long, "is_long");
    chk("R1", {rn_idx, crd_idx, cp_num, xop, crm_idx, 3'b0, is_load},
        {e_rn[3:0], e_crd[3:0], e_cp[3:0], e_xop[3:0], e_crm[3:0], 3'b0, e_load}, "fields");
  endtask

  // advance one cycle: drive at negedge, model takes effect after posedge
  task automatic step(input bit v, input logic [31:0] w, input logic [31:0] b);
    in_valid = v; instr = w; base_val = b;
    if (v) model(w, b);
    @(posedge clk);
    e_valid = v;
    if (v) begin
      e_start = p_start; e_wb = p_wb; e_ext = p_ext; e_err = p_err; e_long = p_long;
      e_load = p_load; e_rn = p_rn; e_crd = p_crd; e_cp = p_cp; e_xop = p_xop; e_crm = p_crm;
      if (p_wb) e_wbv = p_wbv;
    end
    @(negedge clk);
    compare_all();
  endtask

  function automatic logic [31:0] mk(input bit p, input bit u, input bit n, input bit w,
                                     input bit l, input int rn, input int crd, input int cp,
                                     input int imm);
    return {4'hE, 3'b110, p, u, n, w, l, rn[3:0], crd[3:0], cp[3:0], imm[7:0]};
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    e_start = 0; e_wbv = 0; e_wb = 0; e_ext = 0; e_err = 0; e_long = 0; e_load = 0;
    e_valid = 0; e_rn = 0; e_crd = 0; e_cp = 0; e_xop = 0; e_crm = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare_all(); // R10 reset state
    rst_n = 1'b1;
    // R3 unindexed
    step(1, mk(0,1,0,0,1, 3, 5, 15, 8'h10), 32'h0000_1000);
    // R4 post-indexed up, long
    step(1, mk(0,1,1,1,0, 2, 1, 14, 8'h04), 32'h0000_2000);
    // R4 post-indexed down
    step(1, mk(0,0,0,1,1, 2, 1, 14, 8'h04), 32'h0000_2000);
    // R5 offset down
    step(1, mk(1,0,0,0,1, 7, 0, 15, 8'hFF), 32'h0001_0000);
    // R5 offset up
    step(1, mk(1,1,1,0,0, 7, 0, 15, 8'h01), 32'h0001_0000);
    // R6 pre-indexed
    step(1, mk(1,1,0,1,1, 9, 4, 15, 8'h20), 32'h8000_0000);
    // R10 hold with idle gaps
    step(0, 32'hFFFF_FFFF, 32'h1234_5678);
    step(0, 32'h0, 32'h0);
    // R11 wrap upward and downward
    step(1, mk(1,1,0,1,0, 1, 1, 15, 8'h10), 32'hFFFF_FFF0);
    step(1, mk(1,0,0,0,0, 1, 1, 15, 8'h02), 32'h0000_0004);
    // R7 extension space, clean
    step(1, mk(0,0,1,0,1, 4, 6, 15, 8'h3A), 32'hDEAD_BEEF);
    // R8 r15 in first register slot, then second
    step(1, mk(0,0,0,0,0, 4, 15, 15, 8'h21), 32'h0);
    step(1, mk(0,0,0,0,1, 15, 4, 15, 8'h21), 32'h0);
    // R8 r15 as base in a load/store does not flag
    step(1, mk(1,1,0,0,1, 15, 15, 15, 8'h00), 32'h100);
    // random mix (R1 R2 R9)
    for (int i = 0; i < 400; i++) begin
      step(($urandom % 4) != 0, $urandom, $urandom);
    end
    // R10 reset clears outputs
    rst_n = 1'b0; in_valid = 1'b0;
    @(posedge clk); @(negedge clk);
    e_start = 0; e_wbv = 0; e_wb = 0; e_ext = 0; e_err = 0; e_long = 0; e_load = 0;
    e_valid = 0; e_rn = 0; e_crd = 0; e_cp = 0; e_xop = 0; e_crm = 0;
    compare_all();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule